// File: doc/BRIEF.md
# Boot ROM Window Decoder

This block watches memory cycles on a simple host bus: a one-clock address phase marked by `bus_valid`, carrying `bus_addr` and `bus_write`. It decides whether the address falls in one of two boot ROM windows. One window sits at the top of the 32-bit address space. The other ends at the 1 MB boundary.

On a hit, the block claims the cycle. It then runs a fixed-length 8-bit expansion-bus memory cycle: the active-low ROM chip select together with the matching read or write strobe. Afterwards it pulses `done` for one clock.

Two 8-bit control registers are written and read through a small register port:
- The boot control register sets the width of each window and gates ROM writes for flash programming.
- The claim control register selects the claim style. Positive claiming takes the cycle at once. Subtractive claiming waits four clocks and backs off if another target claims first.

Top module: `boot_rom_decoder`

## Requirements
- R1: After reset, the boot control register (`cfg_sel`=0) reads 0xF8 and the claim control register (`cfg_sel`=1) reads 0x20. `claim` and `done` are low, and `rom_cs_n`, `mem_rd_n` and `mem_wr_n` are high.
- R2: The upper window is 0xFFFC0000–0xFFFFFFFF when boot control bit 2 is 0, and 0xFF000000–0xFFFFFFFF when bit 2 is 1. An address phase outside both windows produces no claim, strobe or `done`.
- R3: The lower window is 0x000F0000–0x000FFFFF when boot control bit 0 is 0, and 0x000E0000–0x000FFFFF when bit 0 is 1.
- R4: With claim control bit 5 at 1 (positive), `claim` is high for one clock, in the clock right after the address phase edge. That edge is clock 0, and `claim` shows in cycle 0 after it.
- R5: With claim control bit 5 at 0 (subtractive), `other_claim` is sampled on the four edges after the address phase. If it is seen high on any of them, the block never claims, strobes or signals `done` for that cycle. Otherwise `claim` is high in cycle 4 and the rest of the cycle is shifted by four clocks.
- R6: A read hit drives `rom_cs_n` and `mem_rd_n` low for exactly three clocks, starting in the `claim` clock. `done` is high for the single clock after that.
- R7: A write hit with boot control bit 1 at 1 drives `rom_cs_n` and `mem_wr_n` low for three clocks, starting in the `claim` clock. `done` follows as in R6.
- R8: A write hit with boot control bit 1 at 0 is still claimed and still completes with `done` at the same clocks. `rom_cs_n`, `mem_rd_n` and `mem_wr_n` stay high throughout.
- R9: Register bits not named above store and read back whatever was written, and do not change decoding.
- R10: A register write accepted while a cycle is pending or strobing is deferred. Readback shows the old value up to and including the `done` clock, and the new value from the next clock on.
- R11: Address phases that arrive while a cycle is in progress are ignored. In positive mode, `other_claim` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Address phase strobe, one clock |
| bus_addr | input | 32 | Host memory address |
| bus_write | input | 1 | 1 = write cycle, 0 = read cycle |
| other_claim | input | 1 | Another target has claimed the cycle |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = boot control, 1 = claim control |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Committed value of the selected register |
| claim | output | 1 | One-clock claim pulse |
| rom_cs_n | output | 1 | ROM chip select, active low |
| mem_rd_n | output | 1 | Expansion memory read strobe, active low |
| mem_wr_n | output | 1 | Expansion memory write strobe, active low |
| done | output | 1 | One-clock completion pulse |

## Verification
The address phase edge is counted as clock 0, and every output is due at a fixed offset from it:
- `claim` is due in cycle 0 (positive) or cycle 4 (subtractive).
- The strobes are due in the three clocks that follow.
- `done` is due in cycle 3 or cycle 7.

For every cycle from 0 to 9, the bench samples all five outputs at the falling edge and compares each against a value it computes from the address, direction, configuration and the cycle at which `other_claim` was raised. Register readback is sampled at the falling edge after the write edge. For the deferred case it is sampled in the two clocks before the commit edge and in the clock after it.

// File: rtl/brd_pkg.sv
package brd_pkg;

    localparam int ADDR_W     = 32;
    localparam int REG_W      = 8;

    // boot control field positions (software visible)
    localparam int BC_LO_WIDE = 0;
    localparam int BC_WR_EN   = 1;
    localparam int BC_UP_WIDE = 2;
    // claim control field position
    localparam int CC_POSITIVE = 5;

    localparam logic [REG_W-1:0] BOOT_RST  = 8'hF8;
    localparam logic [REG_W-1:0] CLAIM_RST = 8'h20;

    localparam int WAIT_CLKS   = 4;
    localparam int STROBE_CLKS = 3;
    localparam int CNT_W = $clog2(((WAIT_CLKS > STROBE_CLKS) ? WAIT_CLKS : STROBE_CLKS) + 1);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_DONE   = 2'd3
    } cyc_state_t;

    typedef struct packed {
        logic is_write;
        logic wr_enable;
        logic positive;
    } cyc_info_t;

    typedef struct packed {
        logic lo_wide;
        logic up_wide;
        logic wr_enable;
        logic positive;
    } rom_cfg_t;

endpackage

// File: rtl/brd_window.sv
module brd_window #(
    parameter int ADDR_W    = 32,
    parameter int END_LG    = 32,
    parameter int NARROW_LG = 18,
    parameter int WIDE_LG   = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    output logic              hit
);
    // Window occupies the top 2^size bytes below 2^END_LG.
    localparam logic [ADDR_W:0] END_V   = (ADDR_W+1)'(1) << END_LG;
    localparam logic [ADDR_W:0] SIZE_N  = (ADDR_W+1)'(1) << NARROW_LG;
    localparam logic [ADDR_W:0] SIZE_W  = (ADDR_W+1)'(1) << WIDE_LG;
    localparam logic [ADDR_W:0] BASE_NX = END_V - SIZE_N;
    localparam logic [ADDR_W:0] BASE_WX = END_V - SIZE_W;
    localparam logic [ADDR_W:0] MASK_NX = ~(SIZE_N - 1);
    localparam logic [ADDR_W:0] MASK_WX = ~(SIZE_W - 1);
    localparam logic [ADDR_W-1:0] BASE_N = BASE_NX[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] BASE_W = BASE_WX[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] MASK_N = MASK_NX[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] MASK_W = MASK_WX[ADDR_W-1:0];

    logic [ADDR_W-1:0] mask_sel;
    logic [ADDR_W-1:0] base_sel;

    always_comb begin
        mask_sel = wide ? MASK_W : MASK_N;
        base_sel = wide ? BASE_W : BASE_N;
        hit      = (addr & mask_sel) == base_sel;
    end
endmodule

// File: rtl/brd_cfg_regs.sv
module brd_cfg_regs
    import brd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             sel,
    input  logic [REG_W-1:0] wdata,
    input  logic             busy,
    output logic [REG_W-1:0] rdata,
    output rom_cfg_t         cfg
);
    localparam int NREG = 2;

    logic [REG_W-1:0] regs_q [NREG];
    logic [REG_W-1:0] pend_d [NREG];
    logic [NREG-1:0]  pend_v;

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        localparam logic [REG_W-1:0] RST_V = (gi == 0) ? BOOT_RST : CLAIM_RST;
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[gi] <= RST_V;
                pend_d[gi] <= '0;
                pend_v[gi] <= 1'b0;
            end else begin
                if (!busy && pend_v[gi]) begin
                    regs_q[gi] <= pend_d[gi];
                    pend_v[gi] <= 1'b0;
                end
                if (wr && (sel == 1'(gi))) begin
                    if (busy) begin
                        pend_d[gi] <= wdata;
                        pend_v[gi] <= 1'b1;
                    end else begin
                        regs_q[gi] <= wdata;
                        pend_v[gi] <= 1'b0;
                    end
                end
            end
        end
    end

    always_comb begin
        rdata         = sel ? regs_q[1] : regs_q[0];
        cfg.lo_wide   = regs_q[0][BC_LO_WIDE];
        cfg.up_wide   = regs_q[0][BC_UP_WIDE];
        cfg.wr_enable = regs_q[0][BC_WR_EN];
        cfg.positive  = regs_q[1][CC_POSITIVE];
    end

    // committed registers never move while a cycle is in flight
    p_hold_busy_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(regs_q[0]) && $stable(regs_q[1])));
endmodule

// File: rtl/brd_cycle_fsm.sv
module brd_cycle_fsm
    import brd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic is_write,
    input  logic wr_enable,
    input  logic positive,
    input  logic other_claim,
    output logic claim,
    output logic busy,
    output logic done,
    output logic rom_cs_n,
    output logic mem_rd_n,
    output logic mem_wr_n
);
    cyc_state_t        st;
    cyc_info_t         info;
    logic [CNT_W-1:0]  cnt;
    logic              active;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            info  <= '0;
            cnt   <= '0;
            claim <= 1'b0;
        end else begin
            claim <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    info <= '{is_write: is_write, wr_enable: wr_enable, positive: positive};
                    cnt  <= '0;
                    if (positive) begin
                        st    <= ST_ACTIVE;
                        claim <= 1'b1;
                    end else begin
                        st <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (other_claim) begin
                        st <= ST_IDLE;
                    end else if (cnt == CNT_W'(WAIT_CLKS - 1)) begin
                        st    <= ST_ACTIVE;
                        claim <= 1'b1;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_ACTIVE: begin
                    if (cnt == CNT_W'(STROBE_CLKS - 1)) begin
                        st  <= ST_DONE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        active   = (st == ST_ACTIVE);
        busy     = (st == ST_WAIT) || active;
        done     = (st == ST_DONE);
        mem_rd_n = !(active && !info.is_write);
        mem_wr_n = !(active && info.is_write && info.wr_enable);
        rom_cs_n = !(active && (!info.is_write || info.wr_enable));
    end

    // independent length counter for the strobe window
    logic [CNT_W-1:0] act_len;
    always_ff @(posedge clk) begin
        if (rst || !active) act_len <= '0;
        else                act_len <= act_len + 1'b1;
    end

    p_strobe_len_r6: assert property (@(posedge clk) disable iff (rst)
        active |-> (act_len < CNT_W'(STROBE_CLKS)));
    p_done_after_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(active));
    p_pos_claim_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && start && positive) |=> (claim && active));
    p_sub_backoff_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && other_claim) |=> (!claim && !active && !done));
    p_claim_done_excl_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({claim, done}));
    p_no_wr_gate_r8: assert property (@(posedge clk) disable iff (rst)
        (!mem_wr_n) |-> (!rom_cs_n && mem_rd_n));
endmodule

// File: rtl/boot_rom_decoder.sv
module boot_rom_decoder
    import brd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_write,
    input  logic              other_claim,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic              claim,
    output logic              rom_cs_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              done
);
    rom_cfg_t cfg;
    logic     busy;
    logic     hit_up, hit_lo, start;

    brd_cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .busy  (busy),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    brd_window #(.ADDR_W(ADDR_W), .END_LG(ADDR_W), .NARROW_LG(18), .WIDE_LG(24)) u_win_up (
        .addr (bus_addr),
        .wide (cfg.up_wide),
        .hit  (hit_up)
    );

    brd_window #(.ADDR_W(ADDR_W), .END_LG(20), .NARROW_LG(16), .WIDE_LG(17)) u_win_lo (
        .addr (bus_addr),
        .wide (cfg.lo_wide),
        .hit  (hit_lo)
    );

    assign start = bus_valid && (hit_up || hit_lo);

    brd_cycle_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .is_write    (bus_write),
        .wr_enable   (cfg.wr_enable),
        .positive    (cfg.positive),
        .other_claim (other_claim),
        .claim       (claim),
        .busy        (busy),
        .done        (done),
        .rom_cs_n    (rom_cs_n),
        .mem_rd_n    (mem_rd_n),
        .mem_wr_n    (mem_wr_n)
    );

    p_windows_disjoint_r2: assert property (@(posedge clk) disable iff (rst)
        !(hit_up && hit_lo));
endmodule

// File: tb/boot_rom_decoder_tb_top.sv
`timescale 1ns/1ps
module boot_rom_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_valid, bus_write, other_claim;
    logic [31:0] bus_addr;
    logic        cfg_wr, cfg_sel;
    logic [7:0]  cfg_wdata, cfg_rdata;
    logic        claim, rom_cs_n, mem_rd_n, mem_wr_n, done;

    int vectors = 0;
    int miscompares = 0;
    logic [7:0] cur_boot = 8'hF8;
    logic [7:0] cur_mode = 8'h20;

    always #2.5 clk = ~clk;

    boot_rom_decoder dut_i (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_write(bus_write), .other_claim(other_claim), .cfg_wr(cfg_wr),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .claim(claim), .rom_cs_n(rom_cs_n), .mem_rd_n(mem_rd_n),
        .mem_wr_n(mem_wr_n), .done(done)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic in_window(input logic [31:0] a);
        logic up, lo;
        up = cur_boot[2] ? (a >= 32'hFF00_0000) : (a >= 32'hFFFC_0000);
        lo = (a < 32'h0010_0000) &&
             (cur_boot[0] ? (a >= 32'h000E_0000) : (a >= 32'h000F_0000));
        return up || lo;
    endfunction

    task automatic write_reg(input logic s, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (s) cur_mode = d; else cur_boot = d;
        #0.5 chk(s ? "R9 claim reg readback" : "R9 boot reg readback", cfg_rdata, d);
    endtask

    // One host cycle; oc_n is the cycle in which other_claim is raised (-1: never)
    task automatic run_cycle(input logic [31:0] a, input logic w, input int oc_n);
        logic hit, pos, we, abandon;
        int   base;
        string tag;
        hit = in_window(a);
        pos = cur_mode[5];
        we  = cur_boot[1];
        abandon = !pos && (oc_n >= 0) && (oc_n <= 3);
        base = pos ? 0 : 4;
        if (!hit)          tag = (a[31] ? "R2 miss/upper" : "R3 miss/lower");
        else if (abandon)  tag = "R5 back-off";
        else if (pos && oc_n >= 0) tag = "R11 other_claim ignored";
        else if (w && !we) tag = "R8 gated write";
        else if (w)        tag = "R7 flash write";
        else if (pos)      tag = "R4 positive read";
        else               tag = "R6 subtractive read";
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_write = w;
        @(negedge clk);
        bus_valid = 1'b0;
        for (int n = 0; n < 10; n++) begin
            logic act, c_e, d_e;
            logic [7:0] got, exp;
            other_claim = (n == oc_n);
            act = hit && !abandon && (n >= base) && (n < base + 3);
            c_e = hit && !abandon && (n == base);
            d_e = hit && !abandon && (n == base + 3);
            exp = {3'b000, c_e, !(act && (!w || we)), !(act && !w), !(act && w && we), d_e};
            #0.5 got = {3'b000, claim, rom_cs_n, mem_rd_n, mem_wr_n, done};
            if (got !== exp)
                $display("  addr=%h wr=%0b boot=%h mode=%h cyc=%0d", a, w, cur_boot, cur_mode, n);
            chk(tag, got, exp);
            @(negedge clk);
        end
        other_claim = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [31:0] addrs [13];
        addrs = '{32'h000D_FFFF, 32'h000E_0000, 32'h000E_FFFF, 32'h000F_0000,
                  32'h000F_FFFF, 32'h0010_0000, 32'h100F_0000, 32'h7FFF_FFFF,
                  32'hFEFF_FFFF, 32'hFF00_0000, 32'hFFFB_FFFF, 32'hFFFC_0000,
                  32'hFFFF_FFFF};
        rst = 1'b1; bus_valid = 1'b0; bus_addr = '0; bus_write = 1'b0;
        other_claim = 1'b0; cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        #0.5 chk("R1 boot reg reset", cfg_rdata, 8'hF8);
        chk("R1 idle outputs", {3'b0, claim, rom_cs_n, mem_rd_n, mem_wr_n, done}, 8'b0000_1110);
        cfg_sel = 1'b1;
        #0.5 chk("R1 claim reg reset", cfg_rdata, 8'h20);

        // sweep: claim mode x boot config x direction x boundary addresses
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 8; c++) begin
                logic [4:0] hi;
                hi = 5'((c * 7 + m * 13 + 3) & 31);
                write_reg(1'b0, {hi, 3'(c)});              // R9: odd upper bits
                write_reg(1'b1, m[0] ? 8'hBB : 8'h9B);      // bit 5 picks mode
                for (int w = 0; w < 2; w++)
                    for (int i = 0; i < 13; i++)
                        run_cycle(addrs[i], w[0], -1);
            end
        end

        // R5 back-off boundary: raised in cycle 0 and 3 abandons, 4 is too late
        write_reg(1'b0, 8'hF8);
        write_reg(1'b1, 8'h00);
        run_cycle(32'hFFFF_0000, 1'b0, 0);
        run_cycle(32'hFFFF_0000, 1'b0, 3);
        run_cycle(32'h000F_8000, 1'b0, 4);
        // R11 other_claim ignored in positive mode
        write_reg(1'b1, 8'h20);
        run_cycle(32'hFFFF_0000, 1'b0, 1);

        // R10 deferred register write, R11 address phase while busy
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = 32'h000F_1234; bus_write = 1'b0;
        @(negedge clk);                                // cycle 0
        bus_valid = 1'b0;
        @(negedge clk);                                // cycle 1
        cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = 8'h07;
        bus_valid = 1'b1; bus_addr = 32'hFFFF_FFF0;
        @(negedge clk);                                // cycle 2
        cfg_wr = 1'b0; bus_valid = 1'b0;
        #0.5 chk("R10 old value while strobing", cfg_rdata, 8'hF8);
        @(negedge clk);                                // cycle 3 (done)
        #0.5 chk("R10 old value in done clock", cfg_rdata, 8'hF8);
        chk("R6 done clock", {7'b0, done}, 8'h01);
        @(negedge clk);                                // cycle 4
        #0.5 chk("R10 new value after done", cfg_rdata, 8'h07);
        cur_boot = 8'h07;
        for (int n = 4; n < 9; n++) begin
            #0.5 chk("R11 busy address phase ignored",
                     {3'b0, claim, rom_cs_n, mem_rd_n, mem_wr_n, done}, 8'b0000_1110);
            @(negedge clk);
        end
        // the new config is live: 16 MB upper window, writes enabled
        run_cycle(32'hFF12_3456, 1'b1, -1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule